// File: doc/BRIEF.md
# 3D Line Voxel Path Generator

This block turns a pair of integer voxel coordinates in a volumetric display space into the ordered list of voxels that trace the straight segment between them. A single `go` pulse loads the two endpoints. The block then streams one voxel per step on a valid/ready output. The stream begins at the start voxel and finishes at the end voxel, and the final voxel carries a last flag.

Each step chooses the next voxel by scoring all seven forward neighbours of the current voxel at the same time. These neighbours lie in the octant set by the signs of the segment direction. A neighbour's score is the squared magnitude of the cross product between its offset from the start point and the direction vector. This value is proportional to the squared distance from the neighbour's centre to the ideal line, so no division or square root is needed. The neighbour with the lowest score wins. A step takes a fixed three cycles when the consumer is always ready.

Top module: `voxel_line_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `done` and `vox_valid` are all low.
- R2: A `go` sampled while `busy` is low loads the endpoints. In the next cycle `busy` is high, `done` is low and `vox_valid` is high, with `vox_x/y/z` equal to the start coordinates.
- R3: A `go` sampled while `busy` is high is ignored, and the voxel stream in progress continues unchanged.
- R4: Let the direction be D = end − start. After an accepted voxel C0 that is not last, the next voxel is chosen as follows. Index the neighbour step sets (x,y,z) as 0:(1,1,1), 1:(1,1,0), 2:(1,0,1), 3:(0,1,1), 4:(1,0,0), 5:(0,1,0), 6:(0,0,1). A step of 1 on an axis moves by −1 if D on that axis is negative and by +1 otherwise. A set is excluded if it steps on any axis where C0 already equals the end coordinate. Among the remaining sets, the winner has the smallest |(C − start) × D|², and ties go to the lowest index.
- R5: Consecutive voxels differ by at most one on each axis and are never equal, so the path has no gaps and no repeats.
- R6: `vox_last` is high on the voxel equal to the end coordinates and on no other. When start equals end, exactly one voxel is emitted and it has `vox_last` high.
- R7: While `vox_valid` is high and `vox_ready` is low, `vox_valid`, `vox_x/y/z` and `vox_last` hold their values into the next cycle.
- R8: In the cycle after the last voxel is accepted, `done` is high and `busy` is low. `done` stays high until the next accepted `go`.
- R9: After a non-last voxel is accepted, `vox_valid` is low for two cycles and high in the third.
- R10: Endpoints anywhere in the signed 10-bit range −512..511 on every axis give the R4 sequence, with no score overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Load endpoints and begin, honoured only while idle |
| start_x | input | CW | Start voxel X, signed |
| start_y | input | CW | Start voxel Y, signed |
| start_z | input | CW | Start voxel Z, signed |
| end_x | input | CW | End voxel X, signed |
| end_y | input | CW | End voxel Y, signed |
| end_z | input | CW | End voxel Z, signed |
| busy | output | 1 | A segment is being generated |
| done | output | 1 | Last segment finished, held until next go |
| vox_valid | output | 1 | Output voxel present |
| vox_ready | input | 1 | Consumer accepts the voxel |
| vox_x | output | CW | Output voxel X, signed |
| vox_y | output | CW | Output voxel Y, signed |
| vox_z | output | CW | Output voxel Z, signed |
| vox_last | output | 1 | Output voxel is the end voxel |

## Verification
Internal faults show up on the output stream within one step, which is three cycles. A wrong score, a wrong exclusion or a wrong tie order produces a voxel that differs from the bench's own neighbour search on the very next accepted output. A corrupted current-position register shows up as a jump that breaks adjacency, or as a last flag that arrives early or never arrives. Control faults show up as stream contents that change during a stall, a gap other than two empty cycles, or `done`/`busy` levels that are wrong in the cycle after the final handshake.

// File: rtl/voxel_line_pkg.sv
package voxel_line_pkg;

  localparam int NUM_CAND = 7;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EMIT,
    ST_CALC,
    ST_PICK
  } vlg_state_e;

  // Step set per candidate, bit 2 = X, bit 1 = Y, bit 0 = Z.
  // Index order is the tie-break priority: more axes first, then X, Y, Z.
  function automatic logic [2:0] cand_steps(input int idx);
    logic [2:0] s;
    case (idx)
      0:       s = 3'b111;
      1:       s = 3'b110;
      2:       s = 3'b101;
      3:       s = 3'b011;
      4:       s = 3'b100;
      5:       s = 3'b010;
      default: s = 3'b001;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/vlg_cand_score.sv
module vlg_cand_score #(
  parameter int CW  = 10,
  parameter int IDX = 0
) (
  input  logic                           clk,
  input  logic                           calc_en,
  input  logic signed [CW-1:0]           cur_x,
  input  logic signed [CW-1:0]           cur_y,
  input  logic signed [CW-1:0]           cur_z,
  input  logic signed [CW-1:0]           org_x,
  input  logic signed [CW-1:0]           org_y,
  input  logic signed [CW-1:0]           org_z,
  input  logic signed [CW:0]             dir_x,
  input  logic signed [CW:0]             dir_y,
  input  logic signed [CW:0]             dir_z,
  input  logic signed [CW-1:0]           end_x,
  input  logic signed [CW-1:0]           end_y,
  input  logic signed [CW-1:0]           end_z,
  output logic signed [CW-1:0]           cand_x,
  output logic signed [CW-1:0]           cand_y,
  output logic signed [CW-1:0]           cand_z,
  output logic [2*(2*(CW+1)+1)+1:0]      score,
  output logic                           ok
);
  localparam int DW = CW + 1;
  localparam int PW = 2 * DW;
  localparam int XW = PW + 1;
  localparam int SQ = 2 * XW;
  localparam int SW = SQ + 2;
  localparam logic [2:0] STP = voxel_line_pkg::cand_steps(IDX);

  logic signed [CW-1:0] nx, ny, nz;
  logic                 n_ok;
  logic signed [DW-1:0] rx, ry, rz;
  logic signed [PW-1:0] rxw, ryw, rzw, dxw, dyw, dzw;
  logic signed [XW-1:0] c0, c1, c2;
  logic [XW-1:0]        a0, a1, a2;
  logic [SQ-1:0]        s0, s1, s2;
  logic [SW-1:0]        sum;

  always_comb begin
    nx = cur_x;
    ny = cur_y;
    nz = cur_z;
    if (STP[2]) nx = dir_x[DW-1] ? cur_x - CW'(1) : cur_x + CW'(1);
    if (STP[1]) ny = dir_y[DW-1] ? cur_y - CW'(1) : cur_y + CW'(1);
    if (STP[0]) nz = dir_z[DW-1] ? cur_z - CW'(1) : cur_z + CW'(1);
    n_ok = (!STP[2] || (cur_x != end_x)) &&
           (!STP[1] || (cur_y != end_y)) &&
           (!STP[0] || (cur_z != end_z));
  end

  always_comb begin
    rx  = DW'(nx) - DW'(org_x);
    ry  = DW'(ny) - DW'(org_y);
    rz  = DW'(nz) - DW'(org_z);
    rxw = PW'(rx);
    ryw = PW'(ry);
    rzw = PW'(rz);
    dxw = PW'(dir_x);
    dyw = PW'(dir_y);
    dzw = PW'(dir_z);
    c0  = XW'(ryw * dzw) - XW'(rzw * dyw);
    c1  = XW'(rzw * dxw) - XW'(rxw * dzw);
    c2  = XW'(rxw * dyw) - XW'(ryw * dxw);
    a0  = c0[XW-1] ? XW'(-c0) : XW'(c0);
    a1  = c1[XW-1] ? XW'(-c1) : XW'(c1);
    a2  = c2[XW-1] ? XW'(-c2) : XW'(c2);
    s0  = SQ'(a0) * SQ'(a0);
    s1  = SQ'(a1) * SQ'(a1);
    s2  = SQ'(a2) * SQ'(a2);
    sum = SW'(s0) + SW'(s1) + SW'(s2);
  end

  always_ff @(posedge clk) begin
    if (calc_en) begin
      cand_x <= nx;
      cand_y <= ny;
      cand_z <= nz;
      score  <= sum;
      ok     <= n_ok;
    end
  end

endmodule

// File: rtl/vlg_argmin.sv
module vlg_argmin #(
  parameter int N    = 7,
  parameter int SW   = 48,
  parameter int SELW = 3
) (
  input  logic [N*SW-1:0] scores,
  input  logic [N-1:0]    ok,
  output logic [SELW-1:0] sel
);
  logic [SW-1:0] best;
  logic          found;

  always_comb begin
    sel   = '0;
    best  = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (ok[i] && (!found || (scores[i*SW +: SW] < best))) begin
        sel   = SELW'(i);
        best  = scores[i*SW +: SW];
        found = 1'b1;
      end
    end
  end

endmodule

// File: rtl/voxel_line_gen.sv
module voxel_line_gen #(
  parameter int CW = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 go,
  input  logic signed [CW-1:0] start_x,
  input  logic signed [CW-1:0] start_y,
  input  logic signed [CW-1:0] start_z,
  input  logic signed [CW-1:0] end_x,
  input  logic signed [CW-1:0] end_y,
  input  logic signed [CW-1:0] end_z,
  output logic                 busy,
  output logic                 done,
  output logic                 vox_valid,
  input  logic                 vox_ready,
  output logic signed [CW-1:0] vox_x,
  output logic signed [CW-1:0] vox_y,
  output logic signed [CW-1:0] vox_z,
  output logic                 vox_last
);
  import voxel_line_pkg::*;

  localparam int DW   = CW + 1;
  localparam int XW   = 2 * DW + 1;
  localparam int SW   = 2 * XW + 2;
  localparam int SELW = $clog2(NUM_CAND);

  vlg_state_e state;

  logic signed [CW-1:0] cur_x, cur_y, cur_z;
  logic signed [CW-1:0] org_x, org_y, org_z;
  logic signed [CW-1:0] tgt_x, tgt_y, tgt_z;
  logic signed [DW-1:0] dir_x, dir_y, dir_z;

  logic signed [CW-1:0] cx [NUM_CAND];
  logic signed [CW-1:0] cy [NUM_CAND];
  logic signed [CW-1:0] cz [NUM_CAND];
  logic [SW-1:0]        sc [NUM_CAND];
  logic [NUM_CAND-1:0]  c_ok;
  logic [NUM_CAND*SW-1:0] sc_flat;
  logic [SELW-1:0]      win;
  logic signed [CW-1:0] nxt_x, nxt_y, nxt_z;

  for (genvar g = 0; g < NUM_CAND; g++) begin : g_cand
    vlg_cand_score #(.CW(CW), .IDX(g)) u_score (
      .clk    (clk),
      .calc_en(state == ST_CALC),
      .cur_x  (cur_x),
      .cur_y  (cur_y),
      .cur_z  (cur_z),
      .org_x  (org_x),
      .org_y  (org_y),
      .org_z  (org_z),
      .dir_x  (dir_x),
      .dir_y  (dir_y),
      .dir_z  (dir_z),
      .end_x  (tgt_x),
      .end_y  (tgt_y),
      .end_z  (tgt_z),
      .cand_x (cx[g]),
      .cand_y (cy[g]),
      .cand_z (cz[g]),
      .score  (sc[g]),
      .ok     (c_ok[g])
    );
    assign sc_flat[g*SW +: SW] = sc[g];
  end

  vlg_argmin #(.N(NUM_CAND), .SW(SW), .SELW(SELW)) u_pick (
    .scores(sc_flat),
    .ok    (c_ok),
    .sel   (win)
  );

  assign nxt_x = cx[win];
  assign nxt_y = cy[win];
  assign nxt_z = cz[win];
  assign busy  = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      done      <= 1'b0;
      vox_valid <= 1'b0;
      vox_last  <= 1'b0;
      vox_x     <= '0;
      vox_y     <= '0;
      vox_z     <= '0;
      cur_x     <= '0;
      cur_y     <= '0;
      cur_z     <= '0;
      org_x     <= '0;
      org_y     <= '0;
      org_z     <= '0;
      tgt_x     <= '0;
      tgt_y     <= '0;
      tgt_z     <= '0;
      dir_x     <= '0;
      dir_y     <= '0;
      dir_z     <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (go) begin
            org_x     <= start_x;
            org_y     <= start_y;
            org_z     <= start_z;
            tgt_x     <= end_x;
            tgt_y     <= end_y;
            tgt_z     <= end_z;
            dir_x     <= DW'(end_x) - DW'(start_x);
            dir_y     <= DW'(end_y) - DW'(start_y);
            dir_z     <= DW'(end_z) - DW'(start_z);
            cur_x     <= start_x;
            cur_y     <= start_y;
            cur_z     <= start_z;
            vox_x     <= start_x;
            vox_y     <= start_y;
            vox_z     <= start_z;
            vox_last  <= (start_x == end_x) && (start_y == end_y) && (start_z == end_z);
            vox_valid <= 1'b1;
            done      <= 1'b0;
            state     <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (vox_ready) begin
            vox_valid <= 1'b0;
            if (vox_last) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              state <= ST_CALC;
            end
          end
        end
        ST_CALC: begin
          state <= ST_PICK;
        end
        default: begin
          cur_x     <= nxt_x;
          cur_y     <= nxt_y;
          cur_z     <= nxt_z;
          vox_x     <= nxt_x;
          vox_y     <= nxt_y;
          vox_z     <= nxt_z;
          vox_last  <= (nxt_x == tgt_x) && (nxt_y == tgt_y) && (nxt_z == tgt_z);
          vox_valid <= 1'b1;
          state     <= ST_EMIT;
        end
      endcase
    end
  end

endmodule

// File: rtl/vlg_checker.sv
module vlg_checker #(
  parameter int CW = 10
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 go,
  input logic signed [CW-1:0] start_x,
  input logic signed [CW-1:0] start_y,
  input logic signed [CW-1:0] start_z,
  input logic                 busy,
  input logic                 done,
  input logic                 vox_valid,
  input logic                 vox_ready,
  input logic signed [CW-1:0] vox_x,
  input logic signed [CW-1:0] vox_y,
  input logic signed [CW-1:0] vox_z,
  input logic                 vox_last
);
  logic signed [CW-1:0] px, py, pz;
  logic                 have_prev;
  logic signed [CW+1:0] ddx, ddy, ddz;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_prev <= 1'b0;
      px <= '0;
      py <= '0;
      pz <= '0;
    end else if (vox_valid && vox_ready) begin
      have_prev <= !vox_last;
      px <= vox_x;
      py <= vox_y;
      pz <= vox_z;
    end
  end

  assign ddx = (CW+2)'(vox_x) - (CW+2)'(px);
  assign ddy = (CW+2)'(vox_y) - (CW+2)'(py);
  assign ddz = (CW+2)'(vox_z) - (CW+2)'(pz);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> !busy && !done && !vox_valid);

  assert_go_loads_R2: assert property (@(posedge clk) disable iff (rst)
    (go && !busy) |=> vox_valid && busy && !done &&
                      vox_x == $past(start_x) && vox_y == $past(start_y) && vox_z == $past(start_z));

  assert_valid_means_busy_R2: assert property (@(posedge clk) disable iff (rst)
    vox_valid |-> busy);

  assert_adjacent_R5: assert property (@(posedge clk) disable iff (rst)
    (vox_valid && have_prev && !(vox_ready && $past(vox_valid && vox_ready))) |->
      (ddx >= -1 && ddx <= 1 && ddy >= -1 && ddy <= 1 && ddz >= -1 && ddz <= 1 &&
       !(ddx == 0 && ddy == 0 && ddz == 0)));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (vox_valid && !vox_ready) |=> vox_valid && $stable(vox_x) && $stable(vox_y) &&
                                  $stable(vox_z) && $stable(vox_last));

  assert_finish_R8: assert property (@(posedge clk) disable iff (rst)
    (vox_valid && vox_ready && vox_last) |=> done && !busy);

  assert_done_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));

  assert_step_gap_R9: assert property (@(posedge clk) disable iff (rst)
    (vox_valid && vox_ready && !vox_last) |=> !vox_valid ##1 !vox_valid ##1 vox_valid);

endmodule

bind voxel_line_gen vlg_checker #(.CW(CW)) u_vlg_chk (
  .clk      (clk),
  .rst      (rst),
  .go       (go),
  .start_x  (start_x),
  .start_y  (start_y),
  .start_z  (start_z),
  .busy     (busy),
  .done     (done),
  .vox_valid(vox_valid),
  .vox_ready(vox_ready),
  .vox_x    (vox_x),
  .vox_y    (vox_y),
  .vox_z    (vox_z),
  .vox_last (vox_last)
);

// File: tb/tb_voxel_line_gen.sv
module tb_voxel_line_gen;
  localparam int CW = 10;
  localparam int NV = 7;
  localparam int VEC [NV][6] = '{
    '{0, 0, 0, 5, 3, 2},
    '{-7, 2, 9, 4, -6, 1},
    '{10, 10, 10, 10, 10, 10},
    '{0, 0, 0, 6, 0, 0},
    '{3, -3, 0, -5, 5, 0},
    '{100, -200, 50, -300, 400, -120},
    '{-512, 511, -512, 511, -512, 300}
  };
  localparam int MSX [7] = '{1, 1, 1, 0, 1, 0, 0};
  localparam int MSY [7] = '{1, 1, 0, 1, 0, 1, 0};
  localparam int MSZ [7] = '{1, 0, 1, 1, 0, 0, 1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go = 1'b0;
  logic vox_ready = 1'b0;
  logic signed [CW-1:0] start_x = '0, start_y = '0, start_z = '0;
  logic signed [CW-1:0] end_x = '0, end_y = '0, end_z = '0;
  logic busy, done, vox_valid, vox_last;
  logic signed [CW-1:0] vox_x, vox_y, vox_z;

  int n_chk = 0;
  int n_bad = 0;
  int a_x, a_y, a_z, e_x, e_y, e_z, m_x, m_y, m_z;

  always #2 clk = ~clk;

  voxel_line_gen #(.CW(CW)) dut (
    .clk(clk), .rst(rst), .go(go),
    .start_x(start_x), .start_y(start_y), .start_z(start_z),
    .end_x(end_x), .end_y(end_y), .end_z(end_z),
    .busy(busy), .done(done), .vox_valid(vox_valid), .vox_ready(vox_ready),
    .vox_x(vox_x), .vox_y(vox_y), .vox_z(vox_z), .vox_last(vox_last)
  );

  function automatic longint pk(int x, int y, int z);
    return (longint'(x + 1024) << 24) | (longint'(y + 1024) << 12) | longint'(z + 1024);
  endfunction

  task automatic check(bit good, string req, string what, longint act, longint exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference neighbour search built from the R4 rule.
  task automatic model_step();
    int dx = e_x - a_x, dy = e_y - a_y, dz = e_z - a_z;
    int gx = (dx < 0) ? -1 : 1, gy = (dy < 0) ? -1 : 1, gz = (dz < 0) ? -1 : 1;
    longint best = -1;
    int bx = m_x, by = m_y, bz = m_z;
    for (int k = 0; k < 7; k++) begin
      int cx = m_x + MSX[k] * gx;
      int cy = m_y + MSY[k] * gy;
      int cz = m_z + MSZ[k] * gz;
      longint rx = cx - a_x, ry = cy - a_y, rz = cz - a_z;
      longint q0 = ry * dz - rz * dy;
      longint q1 = rz * dx - rx * dz;
      longint q2 = rx * dy - ry * dx;
      longint s = q0 * q0 + q1 * q1 + q2 * q2;
      bit v = (MSX[k] == 0 || m_x != e_x) && (MSY[k] == 0 || m_y != e_y) &&
              (MSZ[k] == 0 || m_z != e_z);
      if (v && (best < 0 || s < best)) begin
        best = s; bx = cx; by = cy; bz = cz;
      end
    end
    m_x = bx; m_y = by; m_z = bz;
  endtask

  task automatic run_vec(int idx, bit thr, bit inj);
    int nexp, nvox, it, hs_it, px, py, pz;
    bit have_prev, stall_saved, injected, wait_gap;
    longint sv_pos;
    bit sv_last;
    string rq;
    rq = (idx >= 5) ? "R10" : "R4";
    a_x = VEC[idx][0]; a_y = VEC[idx][1]; a_z = VEC[idx][2];
    e_x = VEC[idx][3]; e_y = VEC[idx][4]; e_z = VEC[idx][5];
    m_x = a_x; m_y = a_y; m_z = a_z;
    nexp = 1;
    while (!(m_x == e_x && m_y == e_y && m_z == e_z) && nexp < 5000) begin
      model_step();
      nexp++;
    end
    m_x = a_x; m_y = a_y; m_z = a_z;
    start_x = CW'(a_x); start_y = CW'(a_y); start_z = CW'(a_z);
    end_x = CW'(e_x); end_y = CW'(e_y); end_z = CW'(e_z);
    vox_ready = 1'b0;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    check(vox_valid && busy && !done, "R2", "flags after go", {vox_valid, busy, done}, 3'b110);
    check(pk(vox_x, vox_y, vox_z) == pk(a_x, a_y, a_z), "R2", "first voxel",
          pk(vox_x, vox_y, vox_z), pk(a_x, a_y, a_z));
    nvox = 0; it = 0; hs_it = 0; have_prev = 0; stall_saved = 0; injected = 0; wait_gap = 0;
    px = 0; py = 0; pz = 0; sv_pos = 0; sv_last = 0;
    forever begin
      it++;
      if (stall_saved)
        check(vox_valid && pk(vox_x, vox_y, vox_z) == sv_pos && vox_last == sv_last, "R7",
              "held during stall", pk(vox_x, vox_y, vox_z), sv_pos);
      if (wait_gap && vox_valid) begin
        wait_gap = 0;
        if (!thr) check(it - hs_it == 3, "R9", "step gap", it - hs_it, 3);
      end
      if (inj && nvox == 2 && !injected) begin
        injected = 1;
        go = 1'b1;
        start_x = '0; start_y = '0; start_z = '0;
        end_x = 10'sd1; end_y = 10'sd1; end_z = 10'sd1;
      end else begin
        go = 1'b0;
      end
      vox_ready = thr ? ((it % 3) != 1) : 1'b1;
      stall_saved = vox_valid && !vox_ready;
      sv_pos = pk(vox_x, vox_y, vox_z);
      sv_last = vox_last;
      if (vox_valid && vox_ready) begin
        bit at_end = (m_x == e_x && m_y == e_y && m_z == e_z);
        nvox++;
        check(pk(vox_x, vox_y, vox_z) == pk(m_x, m_y, m_z), rq, "voxel",
              pk(vox_x, vox_y, vox_z), pk(m_x, m_y, m_z));
        check(vox_last == at_end, "R6", "last flag", vox_last, at_end);
        if (have_prev) begin
          int ex = int'(vox_x) - px, ey = int'(vox_y) - py, ez = int'(vox_z) - pz;
          check(ex >= -1 && ex <= 1 && ey >= -1 && ey <= 1 && ez >= -1 && ez <= 1 &&
                !(ex == 0 && ey == 0 && ez == 0), "R5", "adjacency", pk(ex, ey, ez), 0);
        end
        have_prev = 1; px = vox_x; py = vox_y; pz = vox_z;
        if (vox_last || at_end || nvox > nexp + 2) break;
        model_step();
        hs_it = it;
        wait_gap = 1;
      end
      @(negedge clk);
    end
    @(negedge clk);
    go = 1'b0;
    vox_ready = 1'b0;
    check(nvox == nexp, inj ? "R3" : rq, "voxel count", nvox, nexp);
    check(done && !busy && !vox_valid, "R8", "flags after last", {done, busy, vox_valid}, 3'b100);
    repeat (3) @(negedge clk);
    check(done && !busy, "R8", "done held", {done, busy}, 2'b10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !done && !vox_valid, "R1", "in reset", {busy, done, vox_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !vox_valid, "R1", "after reset", {busy, done, vox_valid}, 0);
    for (int v = 0; v < NV; v++) begin
      run_vec(v, v[0], v == 1 || v == 4);
    end
    // R6: single voxel case repeated with the consumer stalling first
    run_vec(2, 1'b1, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule